// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address stream of one SDRAM burst. It fits inside a memory model or inside a controller. A read or write command gives it a starting column, a burst length code and an ordering mode. From the cycle after the command it presents one column per clock on a registered output. The beat count runs in a counter, and a mapping stage turns that count into an address. The mapping uses either wrap-around counting inside the aligned burst block or bit-inversion ordering.

A command can arrive on any clock, including the final beat of the current burst. When it does, it throws away whatever addresses remain and starts a fresh burst of the full programmed length. A full-page burst walks the whole page, wraps from the top column to column zero, and only ends on a burst-stop request. A burst-stop request at any other time has no effect on the burst, but the block raises a flag for it. When no burst is running, the address output holds its last value and the valid output is low.

Top module: `sdram_col_seq`

## Requirements
- R1: `len_code_i` is decoded as follows. If bit 2 is 1, the burst is full page and bits 1:0 are ignored. If bit 2 is 0, the burst is 2^`len_code_i[1:0]` beats long, which gives 1, 2, 4 or 8 beats for codes 0, 1, 2 and 3.
- R2: A `start_i` sampled high at a rising edge makes `valid_o` high and `col_o` equal to the sampled `start_col_i` from that edge on. Each following edge presents the next beat.
- R3: Sequential ordering (`ilv_i` low at start) applies to a burst of length L. At beat k, `col_o` keeps the start column's bits above log2(L) and puts (start + k) mod L in the low log2(L) bits.
- R4: Interleave ordering (`ilv_i` high at start) applies to L = 2, 4 or 8. At beat k, `col_o` equals the start column XOR k.
- R5: On a burst that is not full page, `last_o` is high only on the final beat. If no new start is sampled on that beat, `valid_o` goes low on the next cycle, and from then on `col_o` holds its value and `last_o` is low.
- R6: A full-page burst always counts sequentially, whatever `ilv_i` is. It wraps from column 2^COL_W-1 to column 0 and never raises `last_o`.
- R7: A `stop_i` sampled while a full-page burst is running, with no `start_i` in the same cycle, drives `valid_o` low from the next cycle. `col_o` holds its value.
- R8: A `stop_i` sampled with no full-page burst running, and with no `start_i` in the same cycle, leaves the burst sequence unchanged. It raises `stop_bad_o` for exactly the following cycle.
- R9: A `start_i` sampled during a burst, on any beat including the last, restarts the sequence from the new column. The new burst has the full length and ordering mode given with that command. If `start_i` and `stop_i` are sampled together, the start wins: the stop neither ends the burst nor sets `stop_bad_o`.
- R10: While `rst_n` is low, `valid_o`, `last_o` and `stop_bad_o` are 0 and `col_o` is 0.
- R11: A length-1 burst presents only the start column. `last_o` is high on that beat, and `ilv_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read or write command strobe; starts or restarts a burst |
| start_col_i | input | COL_W | Starting column of the command |
| len_code_i | input | 3 | Burst length code (see R1) |
| ilv_i | input | 1 | 1 = interleave ordering, 0 = sequential ordering |
| stop_i | input | 1 | Burst-stop request |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` carries a burst beat |
| last_o | output | 1 | Final beat of a non-full-page burst |
| stop_bad_o | output | 1 | Previous cycle held an illegal burst-stop |

## Verification
Every output is a register, so each result is due in the cycle after the edge that samples its stimulus. A start shows its column one edge later. Each further beat, the end of a burst after its last beat or after a legal stop, and the illegal-stop flag each take one more edge. The bench changes inputs just after the falling edge. Its behavioural model advances on the rising edge from the same inputs. All four outputs are compared with the model at the following falling edge, once both sides have settled on the same cycle.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
   localparam int unsigned LEN_CODE_W = 3;
   localparam int unsigned MAX_LG     = 3;

   typedef enum logic [1:0] {
      BL_ONE   = 2'd0,
      BL_TWO   = 2'd1,
      BL_FOUR  = 2'd2,
      BL_EIGHT = 2'd3
   } bl_sel_e;

   function automatic logic code_is_full(input logic [LEN_CODE_W-1:0] code);
      return code[LEN_CODE_W-1];
   endfunction

   function automatic bl_sel_e code_sel(input logic [LEN_CODE_W-1:0] code);
      return bl_sel_e'(code[1:0]);
   endfunction
endpackage

// File: rtl/scs_len_decode.sv
module scs_len_decode
   import sdram_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  full_o
);
   localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

   initial begin
      if (COL_W < MAX_LG + 1) $fatal(1, "COL_W too small for an 8-beat burst");
   end

   logic [COL_W-1:0] span;

   always_comb begin
      full_o = code_is_full(code_i);
      span   = ONE << code_sel(code_i);
      mask_o = full_o ? {COL_W{1'b1}} : (span - ONE);
   end
endmodule

// File: rtl/scs_beat_ctr.sv
module scs_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] new_mask_i,
   input  logic             new_full_i,
   input  logic [COL_W-1:0] cur_mask_i,
   input  logic             cur_full_i,
   input  logic             stop_i,
   output logic             act_o,
   output logic             last_o,
   output logic             adv_o,
   output logic [COL_W-1:0] cnt_nxt_o
);
   logic [COL_W-1:0] cnt_q;
   logic             act_q;
   logic             last_q;
   logic             stop_end;

   assign cnt_nxt_o = cnt_q + 1'b1;
   assign stop_end  = stop_i && cur_full_i;
   assign adv_o     = act_q && !start_i && !stop_end && !last_q;
   assign act_o     = act_q;
   assign last_o    = last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         last_q <= 1'b0;
      end else if (start_i) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         last_q <= !new_full_i && (new_mask_i == '0);
      end else if (act_q) begin
         if (stop_end || last_q) begin
            act_q  <= 1'b0;
            last_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_nxt_o;
            last_q <= !cur_full_i && (cnt_nxt_o == cur_mask_i);
         end
      end
   end

   // R3: every advancing beat moves the count by one
   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R9: a start always rewinds the count
   p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == '0) && act_q);
   // R5: the last beat ends the burst unless a start arrives
   p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_q && !start_i) |=> !act_q);
endmodule

// File: rtl/scs_addr_map.sv
module scs_addr_map #(
   parameter int unsigned COL_W  = 8,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] addr_o
);
   logic [COL_W-1:0] seq_addr;
   logic [COL_W-1:0] sum;

   assign sum      = base_i + cnt_i;
   assign seq_addr = (base_i & ~mask_i) | (sum & mask_i);

   generate
      if (ILV_EN) begin : g_ilv
         logic use_ilv;
         assign use_ilv = ilv_i && !full_i;
         assign addr_o  = use_ilv ? (base_i ^ cnt_i) : seq_addr;
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv_i;
         assign addr_o     = seq_addr;
      end
   endgenerate
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import sdram_col_pkg::*;
#(
   parameter int unsigned COL_W  = 8,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ilv_i,
   input  logic                  stop_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o,
   output logic                  stop_bad_o
);
   logic [COL_W-1:0] new_mask;
   logic             new_full;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             ilv_q;
   logic [COL_W-1:0] col_q;
   logic             bad_q;
   logic             act;
   logic             adv;
   logic [COL_W-1:0] cnt_nxt;
   logic [COL_W-1:0] next_addr;

   scs_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i (len_code_i),
      .mask_o (new_mask),
      .full_o (new_full)
   );

   scs_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .new_mask_i (new_mask),
      .new_full_i (new_full),
      .cur_mask_i (mask_q),
      .cur_full_i (full_q),
      .stop_i     (stop_i),
      .act_o      (act),
      .last_o     (last_o),
      .adv_o      (adv),
      .cnt_nxt_o  (cnt_nxt)
   );

   scs_addr_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .base_i (base_q),
      .cnt_i  (cnt_nxt),
      .mask_i (mask_q),
      .full_i (full_q),
      .ilv_i  (ilv_q),
      .addr_o (next_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
         ilv_q  <= 1'b0;
         col_q  <= '0;
         bad_q  <= 1'b0;
      end else begin
         bad_q <= stop_i && !start_i && !(act && full_q);
         if (start_i) begin
            base_q <= start_col_i;
            mask_q <= new_mask;
            full_q <= new_full;
            ilv_q  <= ilv_i;
            col_q  <= start_col_i;
         end else if (adv) begin
            col_q  <= next_addr;
         end
      end
   end

   assign col_o      = col_q;
   assign valid_o    = act;
   assign stop_bad_o = bad_q;

   // R2: a start is visible on the next cycle
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && (col_o == $past(start_col_i)));
   // R6: full page never flags a last beat
   p_full_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_q) |-> !last_o);
   // R3: non-full addresses stay in the aligned block
   p_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !full_q) |-> ((col_o & ~mask_q) == (base_q & ~mask_q)));
   // R7: a legal stop closes the burst
   p_stop_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i && valid_o && full_q) |=> !valid_o);
   // R8: an illegal stop is flagged
   p_stop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i && !(valid_o && full_q)) |=> stop_bad_o);
   // R5: column holds while idle
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> $stable(col_o));
endmodule

// File: tb/sdram_col_seq_bench.sv
`timescale 1ns/100ps
module sdram_col_seq_bench;
   localparam int COL_W = 8;
   localparam int PAGE  = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       valid_o, last_o, stop_bad_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;
   string req = "R2";

   always #2.5 clk = ~clk;

   sdram_col_seq #(.COL_W(COL_W)) u_sdram_col_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .stop_bad_o(stop_bad_o)
   );

   // behavioural reference
   int m_act, m_k, m_len, m_base, m_ilv, m_col, m_last, m_bad;

   function automatic int exp_col(int b, int k, int len, int iv);
      if (len == 0) return (b + k) % PAGE;
      if (iv != 0)  return b ^ k;
      return (b & ~(len - 1)) | ((b + k) % len);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_k = 0; m_len = 1; m_base = 0; m_ilv = 0;
         m_col = 0; m_last = 0; m_bad = 0;
      end else begin
         m_bad = (stop_i && !start_i && !(m_act != 0 && m_len == 0)) ? 1 : 0;
         if (start_i) begin
            m_act  = 1; m_k = 0; m_base = start_col_i; m_ilv = ilv_i;
            m_len  = len_code_i[2] ? 0 : (1 << len_code_i[1:0]);
            m_col  = m_base;
            m_last = (m_len == 1) ? 1 : 0;
         end else if (m_act != 0) begin
            if ((stop_i && m_len == 0) || m_last != 0) begin
               m_act = 0; m_last = 0;
            end else begin
               m_k    = m_k + 1;
               m_col  = exp_col(m_base, m_k, m_len, m_ilv);
               m_last = (m_len != 0 && m_k == m_len - 1) ? 1 : 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         tests++;
         if (valid_o !== m_act[0] || col_o !== m_col[7:0] ||
             last_o !== m_last[0] || stop_bad_o !== m_bad[0]) begin
            fails++;
            $display("FAIL %s valid %0b/%0b col %0d/%0d last %0b/%0b bad %0b/%0b (actual/expected)",
                     req, valid_o, m_act[0], col_o, m_col, last_o, m_last[0],
                     stop_bad_o, m_bad[0]);
         end
      end
   end

   task automatic step(input bit s, input int c, input int code, input bit iv, input bit p);
      @(negedge clk);
      #1;
      start_i = s; start_col_i = c[7:0]; len_code_i = code[2:0]; ilv_i = iv; stop_i = p;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
   endtask

   initial begin
      #20000;
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      tests++;
      if (valid_o !== 1'b0 || last_o !== 1'b0 || stop_bad_o !== 1'b0 || col_o !== 8'd0) begin
         fails++;
         $display("FAIL R10 valid %0b last %0b bad %0b col %0d expected all 0",
                  valid_o, last_o, stop_bad_o, col_o);
      end
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;

      req = "R2/R3 seq len4"; step(1, 6, 2, 0, 0);   idle(6);
      req = "R3 seq len8";    step(1, 13, 3, 0, 0);  idle(10);
      req = "R3 seq len2";    step(1, 9, 1, 0, 0);   idle(4);
      req = "R4 ilv len8";    step(1, 5, 3, 1, 0);   idle(10);
      req = "R4 ilv len4";    step(1, 2, 2, 1, 0);   idle(6);
      req = "R11 len1 ilv";   step(1, 77, 0, 1, 0);  idle(3);
      req = "R5 hold";        idle(4);
      req = "R6 full wrap";   step(1, 250, 4, 1, 0); idle(12);
      req = "R7 full stop";   step(0, 0, 0, 0, 1);   idle(4);
      req = "R8 stop len8";   step(1, 40, 3, 0, 0);  idle(2); step(0, 0, 0, 0, 1); idle(8);
      req = "R8 stop idle";   step(0, 0, 0, 0, 1);   idle(3);
      req = "R9 mid restart"; step(1, 16, 3, 0, 0);  idle(2); step(1, 33, 2, 1, 0); idle(6);
      req = "R9 last restart"; step(1, 3, 1, 0, 0);  idle(1); step(1, 100, 2, 0, 0); idle(6);
      req = "R9 start+stop";  step(1, 200, 4, 0, 0); idle(3); step(1, 7, 7, 0, 1); idle(3);
      req = "R1 code7 full";  idle(2); step(0, 0, 0, 0, 1); idle(3);
      req = "R1 code5 full";  step(1, 254, 5, 0, 0); idle(5); step(0, 0, 0, 0, 1); idle(3);
      req = "R9 back-to-back"; step(1, 1, 0, 0, 0); step(1, 2, 0, 0, 0); step(1, 3, 1, 1, 0); idle(4);

      cmp_on = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule